// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use an external asynchronous static RAM of 512K bytes. The RAM has a 19-bit address, an 8-bit data bus, and active-low chip-select, write-strobe and output-enable pins. On the user side, a request is accepted when valid and ready are both high. A request is either a single-byte write or a single-byte read. When the access has finished, a one-cycle done pulse is returned, and for a read the byte is valid during that pulse.

The RAM's timing limits are given in nanoseconds. They are converted into whole system-clock cycles when the design is elaborated, using a clock-period parameter. The rounding is always upward, and every phase lasts at least one cycle. All pins toward the RAM come from registers, including the enable for the controller's data driver.

A read holds chip-select and output-enable low for the read phase and captures the byte on that phase's last cycle. A write first runs a setup phase, with chip-select low and the strobe still high, so that the RAM releases the bus. It then runs the strobe phase, and the controller drives data only while the strobe is low.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rsp_done is 0 and req_ready is 1.
- R2: A read (req_write=0) holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and a stable mem_addr for the whole read phase. The read phase lasts max(ceil(T_AA/P), ceil(T_DOE/P), ceil(T_RC/P)) cycles, which is 6 at the defaults.
- R3: rsp_rdata equals the RAM byte that was on mem_dq_i at the last edge of the read phase. rsp_done rises exactly one read-phase length after the accepting edge.
- R4: A write (req_write=1) holds mem_we_n low for max(ceil(T_PWE/P), ceil(T_SD/P), ceil(T_SCE/P)) cycles, which is 4 at the defaults. During that time mem_ce_n is low and mem_dq_o holds req_wdata stable, and the RAM byte at req_addr afterwards reads back as req_wdata.
- R5: Before the strobe falls, a write has a setup phase of max(ceil(T_HZOE/P), ceil(T_WC/P) − strobe length) cycles, with a minimum of 1. During setup mem_ce_n is 0, mem_we_n and mem_oe_n are 1, and mem_dq_oe is 0. rsp_done rises setup plus strobe cycles after acceptance, which is 6 at the defaults.
- R6: mem_dq_oe is 1 only while mem_we_n=0 and mem_oe_n=1. mem_oe_n and mem_we_n are never low together, so the controller never drives the bus while the RAM may still be driving it after a read.
- R7: rsp_done is a one-cycle pulse and coincides with mem_ce_n=1. req_ready is 1 only when no access is in progress, and mem_ce_n is 1 whenever req_ready is 1.
- R8: A request held valid while req_ready is 0 is accepted once, and gives exactly one rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on a clock edge with valid and ready both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid while rsp_done is high after a read |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | RAM chip-select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Data the controller drives onto the RAM bus |
| mem_dq_oe | output | 1 | Enable for the controller's driver onto the data bus |
| mem_dq_i | input | 8 | Data read from the RAM bus |

## Verification
The bench's RAM model returns garbage until the address-to-data and enable-to-data times have passed. A controller that captured one cycle early would therefore hand back the garbage byte.

The model keeps driving the bus for the high-impedance delay after a read ends, and it measures strobe width and data setup at every write end. A missing setup phase would show up as bus contention, and a short strobe as a width failure.

Reads and writes are mixed back to back, including a read of a just-written address and the two address extremes. A wrong phase count, a write committed to the wrong place, or a request accepted twice shows up as a latency, data or queue mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPL  = 3'd3,
    ST_END  = 3'd4
  } ctrl_state_t;

  // Round a nanosecond requirement up to whole clock cycles; 0 ns stays 0.
  function automatic int ns_to_cyc(input int t_ns, input int period_ns);
    return (t_ns <= 0) ? 0 : (t_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= din;
  end

  assign dout = data_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,  // read cycle
  parameter int T_AA_NS       = 55,  // address to data
  parameter int T_DOE_NS      = 25,  // output enable to data
  parameter int T_WC_NS       = 55,  // write cycle
  parameter int T_PWE_NS      = 40,  // strobe width
  parameter int T_SCE_NS      = 40,  // select low to write end
  parameter int T_SD_NS       = 25,  // data setup to write end
  parameter int T_HZOE_NS     = 20   // output enable high to bus release
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_RD  = imax(1, imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                              imax(ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_RC_NS, CLK_PERIOD_NS))));
  localparam int N_PWE = imax(1, imax(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                              imax(ns_to_cyc(T_SD_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_SCE_NS, CLK_PERIOD_NS))));
  localparam int N_WSU = imax(1, imax(ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - N_PWE));
  localparam int N_MAX = imax(N_RD, imax(N_PWE, N_WSU));
  localparam int CNT_W = $clog2(N_MAX + 1);

  logic              rst_i_n;
  ctrl_state_t       state_q, state_d;
  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept, cap_en;
  logic              ready_q, done_q, ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic              ready_d, done_d, ce_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  sram_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_i_n)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_rd_capture #(.DW(DATA_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .cap_en (cap_en),
    .din    (mem_dq_i),
    .dout   (rsp_rdata)
  );

  assign accept = req_valid & ready_q;
  assign cap_en = (state_q == ST_RD) & tmr_last;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WSU;
          tmr_val = CNT_W'(N_WSU - 1);
        end else begin
          state_d = ST_RD;
          tmr_val = CNT_W'(N_RD - 1);
        end
      end
      ST_RD:  if (tmr_last) state_d = ST_END;
      ST_WSU: if (tmr_last) begin
        state_d  = ST_WPL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_PWE - 1);
      end
      ST_WPL: if (tmr_last) state_d = ST_END;
      ST_END: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin levels decoded from the next state, then registered
  always_comb begin
    ready_d = (state_d == ST_IDLE);
    done_d  = (state_d == ST_END);
    ce_n_d  = !((state_d == ST_RD) || (state_d == ST_WSU) || (state_d == ST_WPL));
    oe_n_d  = (state_d != ST_RD);
    we_n_d  = (state_d != ST_WPL);
    dq_oe_d = (state_d == ST_WPL);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
      done_q  <= done_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready = ready_q;
  assign rsp_done  = done_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = dq_oe_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW     = 19,
  parameter int MIN_WE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);
  logic [7:0] wl_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wl_cnt_q <= '0;
    else if (mem_we_n)             wl_cnt_q <= '0;
    else if (wl_cnt_q != 8'hff)    wl_cnt_q <= wl_cnt_q + 8'd1;
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R2
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R4
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_cnt_q >= 8'(MIN_WE))); // R4
  AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R6
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R7
  AST_DONE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> mem_ce_n); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !rsp_done)); // R7
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(ADDR_W), .MIN_WE(N_PWE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int P = 10;

  function automatic int cdiv(input int t);
    return (t + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LAT_RD = mx(cdiv(55), cdiv(25));
  localparam int WE_LEN = mx(cdiv(40), cdiv(25));
  localparam int SU_LEN = mx(cdiv(20), cdiv(55) - WE_LEN);
  localparam int LAT_WR = SU_LEN + WE_LEN;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- RAM model (cycle based) ----------------
  bit [7:0] store [int];
  function automatic bit [7:0] init_val(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3c;
  endfunction
  function automatic bit [7:0] ram_rd(input logic [18:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : init_val(a);
  endfunction

  logic        rd_active, act_prev;
  logic [18:0] addr_prev;
  int          age;
  int          hold;
  logic        ram_drive, ram_valid;

  assign rd_active = !mem_ce_n && !mem_oe_n && mem_we_n;
  always @(posedge clk) begin
    act_prev  <= rd_active;
    addr_prev <= mem_addr;
    if (!rd_active)                              age <= 0;
    else if (!act_prev || mem_addr != addr_prev) age <= 1;
    else                                         age <= age + 1;
    if (rd_active)     hold <= cdiv(20);
    else if (hold > 0) hold <= hold - 1;
  end
  assign ram_drive = rd_active || (hold > 0);
  assign ram_valid = rd_active && ((age + 1) * P >= 55) && ((age + 1) * P >= 25);
  assign mem_dq_i  = !ram_drive ? 8'h00 : (ram_valid ? ram_rd(mem_addr) : 8'ha5);

  // Write-side checks and commit, sampled at falling edges
  int          wl_cnt, ds_cnt, ce_cnt, ce_at_w;
  logic        we_low_prev;
  logic [18:0] w_addr;
  logic [7:0]  w_data;
  initial begin
    wl_cnt = 0; ds_cnt = 0; ce_cnt = 0; ce_at_w = 0; we_low_prev = 1'b0;
    w_addr = '0; w_data = '0;
  end
  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe) begin
      check(!ram_drive, "R6 bus contention", 1, 0);
      check(!mem_we_n && mem_oe_n, "R6 drive outside strobe", {mem_we_n, mem_oe_n}, 1);
    end
    if (!mem_ce_n) ce_cnt++; else ce_cnt = 0;
    if (!mem_we_n) begin
      wl_cnt  = we_low_prev ? wl_cnt + 1 : 1;
      ds_cnt  = (mem_dq_oe && we_low_prev && mem_dq_o == w_data) ? ds_cnt + 1 : (mem_dq_oe ? 1 : 0);
      w_data  = mem_dq_o;
      w_addr  = mem_addr;
      ce_at_w = ce_cnt;
    end else if (we_low_prev) begin
      check(wl_cnt >= cdiv(40), "R4 strobe width", wl_cnt, cdiv(40));
      check(ds_cnt >= cdiv(25), "R4 data setup", ds_cnt, cdiv(25));
      check(ce_at_w >= cdiv(40), "R4 select before write end", ce_at_w, cdiv(40));
      check(ce_at_w - wl_cnt >= SU_LEN, "R5 setup before strobe", ce_at_w - wl_cnt, SU_LEN);
      store[int'(w_addr)] = w_data;
    end
    we_low_prev = !mem_we_n;
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit wr; logic [18:0] addr; logic [7:0] data; int acc; } item_t;
  item_t    sbq[$];
  bit [7:0] shadow [int];

  function automatic bit [7:0] shadow_rd(input logic [18:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  task automatic op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    it.wr = wr; it.addr = a; it.acc = cyc;
    it.data = wr ? d : shadow_rd(a);
    if (wr) shadow[int'(a)] = d;
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && rsp_done) begin
    if (sbq.size() == 0) begin
      check(1'b0, "R8 done without request", 1, 0);
    end else begin
      item_t it;
      it = sbq.pop_front();
      if (it.wr) begin
        check(cyc - it.acc - 1 == LAT_WR, "R5 write latency", cyc - it.acc - 1, LAT_WR);
      end else begin
        check(cyc - it.acc - 1 == LAT_RD, "R3 read latency", cyc - it.acc - 1, LAT_RD);
        check(rsp_rdata == it.data, "R3 read data", rsp_rdata, it.data);
      end
      check(mem_ce_n, "R7 select high at done", mem_ce_n, 1);
    end
  end

  // Read-phase pin levels (R2), sampled away from edges
  always @(negedge clk) if (rst_n && !mem_oe_n) begin
    check(!mem_ce_n && mem_we_n && !mem_dq_oe, "R2 read pin levels",
          {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b010);
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lcg;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_oe && !rsp_done, "R1 no drive no done", {mem_dq_oe, rsp_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    op(1'b1, 19'h00000, 8'h5a);
    op(1'b0, 19'h00000, 8'h00);
    op(1'b0, 19'h7ffff, 8'h00);
    op(1'b1, 19'h7ffff, 8'hc3);
    op(1'b0, 19'h7ffff, 8'h00);
    repeat (3) @(negedge clk);
    op(1'b0, 19'h12345, 8'h00);
    op(1'b1, 19'h12345, 8'h81);
    op(1'b0, 19'h12345, 8'h00);
    op(1'b1, 19'h00001, 8'hff);
    op(1'b1, 19'h00002, 8'h00);
    op(1'b0, 19'h00001, 8'h00);
    op(1'b0, 19'h00002, 8'h00);

    lcg = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      op(lcg[31], {lcg[20:18], lcg[27:12]} & 19'h7ff0f, lcg[11:4]);
      if (lcg[2]) repeat (int'(lcg[1:0])) @(negedge clk);
    end

    repeat (LAT_RD + LAT_WR + 4) @(negedge clk);
    check(sbq.size() == 0, "R8 every request answered once", sbq.size(), 0);
    check(req_ready && mem_ce_n, "R7 idle after traffic", {req_ready, mem_ce_n}, 3);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule